// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches the byte stream that a MAC receive front end hands over, one byte per valid beat. Each frame is marked by a start strobe on its first beat and an end strobe on its last. The first byte of a frame is the first destination-address byte, and the last byte is the final CRC byte. The filter counts the length of every frame and works out whether the destination address is the all-ones broadcast address. It then applies a small configuration register to decide whether the frame is kept. The register holds a programmable length limit, a broadcast-reject control, a promiscuous control and a control that blocks reception while the transmitter is busy.

The verdict is given on the end beat of the frame. It consists of an accept bit, a miss bit and a long-frame bit. A separate one-cycle babble interrupt fires on the exact beat where a frame first grows beyond the limit. Unicast and multicast address matching are done elsewhere. Their combined result arrives on a single station-match input, which is sampled on the end beat.

The configuration register is loaded with a write strobe. Two of its bits, the receive-on-transmit block and an interface-mode bit, are frozen while the controller enable is high. Configuration changes take effect from the cycle after the write.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset the length limit reads as 1518, and broadcast reject, promiscuous mode, receive-on-transmit block and interface mode are all 0. No status and no interrupt are output until a frame arrives.
- R2: Frame length counts every beat from the start beat through the end beat, so a frame of N beats has length N. On the end beat, stat_long is 1 exactly when the length is greater than the limit: a frame of limit bytes is not long and a frame of limit+1 bytes is long.
- R3: irq_babble is a one-cycle pulse. It fires once per received frame, on the beat whose length first equals limit+1, and never for a frame of limit bytes or fewer, however long the frame runs.
- R4: A frame is broadcast when its first six bytes are all 0xFF. A frame whose sixth byte is 0xFE is not broadcast. With broadcast reject at 1 and promiscuous mode at 0, a broadcast frame is dropped (accept 0, miss 0), even when station_match is 1.
- R5: With broadcast reject at 1 and promiscuous mode at 1, a broadcast frame is accepted with miss 1.
- R6: With promiscuous mode at 1, a frame that is neither broadcast nor station-matched is accepted with miss 1. A station-matched frame is accepted with miss 0.
- R7: With promiscuous mode at 0, a frame that is neither broadcast nor station-matched is dropped (accept 0, miss 0). A station-matched frame is accepted with miss 0. With broadcast reject at 0, a broadcast frame is accepted with miss 0.
- R8: If receive-on-transmit block is 1 and tx_busy is 1 on the start beat, the frame is blocked. Its status reports accept 0, miss 0 and long 0, and no interrupt fires. With the block bit at 0, tx_busy has no effect.
- R9: tx_busy rising after the start beat of a frame does not affect that frame.
- R10: A write while ctrl_enable is 1 leaves the receive-on-transmit block bit and the interface-mode bit unchanged, but still updates the limit, broadcast reject and promiscuous bits. A write while ctrl_enable is 0 updates all fields.
- R11: stat_valid is 1 only on the end beat of a frame that was opened by a start beat. It is 1 for that single cycle. An end beat with no open frame produces no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_enable | input | 1 | Controller enable; freezes two configuration bits while high |
| cfg_wr | input | 1 | Configuration write strobe |
| wr_max_len | input | LEN_W | Length limit to write |
| wr_bc_reject | input | 1 | Broadcast reject to write |
| wr_promisc | input | 1 | Promiscuous mode to write |
| wr_rx_dis_tx | input | 1 | Receive-on-transmit block to write |
| wr_iface_mode | input | 1 | Interface-mode bit to write |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | First beat of a frame |
| rx_eof | input | 1 | Last beat of a frame |
| rx_data | input | 8 | Received byte |
| station_match | input | 1 | Address-match result from the matcher, sampled on the end beat |
| tx_busy | input | 1 | Transmitter active |
| iface_mode | output | 1 | Current interface-mode bit |
| stat_valid | output | 1 | Frame status valid (end beat) |
| stat_accept | output | 1 | Frame accepted |
| stat_miss | output | 1 | Accepted without an address match |
| stat_long | output | 1 | Frame longer than the limit |
| irq_babble | output | 1 | Oversize interrupt pulse |

## Verification
The status outputs appear in the same cycle as the end beat, because they are decoded from registered frame state and the current byte. The interrupt appears in the same cycle as the beat that takes the length past the limit. A configuration write is seen from the clock edge that ends the write cycle. The bench drives each beat just after a rising edge and samples on the falling edge of that cycle, so each result is compared in the cycle it is due. The monitor also gathers interrupt pulses between status beats. It compares their number with the expected count when the frame's status arrives.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Destination-address class used by the acceptance decision.
  typedef enum logic [1:0] {
    ADDR_OTHER   = 2'd0,
    ADDR_STATION = 2'd1,
    ADDR_BCAST   = 2'd2
  } addr_kind_e;

  // Per-frame verdict delivered on the end beat.
  typedef struct packed {
    logic accept;
    logic miss;
    logic long_f;
  } rx_status_t;

  localparam logic [7:0] BCAST_BYTE = 8'hFF;

endpackage

// File: rtl/rxf_cfg_reg.sv
module rxf_cfg_reg #(
  parameter int unsigned LEN_W       = 14,
  parameter int unsigned DEF_MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_enable,
  input  logic             cfg_wr,
  input  logic [LEN_W-1:0] wr_max_len,
  input  logic             wr_bc_reject,
  input  logic             wr_promisc,
  input  logic             wr_rx_dis_tx,
  input  logic             wr_iface_mode,
  output logic [LEN_W-1:0] max_len,
  output logic             bc_reject,
  output logic             promisc,
  output logic             rx_dis_tx,
  output logic             iface_mode
);

  localparam logic [LEN_W-1:0] RST_MAX = LEN_W'(DEF_MAX_LEN);

  // Named events: which parts of a write land this cycle.
  logic open_write;
  logic locked_write;
  assign open_write   = cfg_wr && !ctrl_enable;
  assign locked_write = cfg_wr && ctrl_enable;

  // Freely writable fields.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_len   <= RST_MAX;
      bc_reject <= 1'b0;
      promisc   <= 1'b0;
    end else if (cfg_wr) begin
      max_len   <= wr_max_len;
      bc_reject <= wr_bc_reject;
      promisc   <= wr_promisc;
    end
  end

  // Fields writable only while the controller is disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dis_tx  <= 1'b0;
      iface_mode <= 1'b0;
    end else if (open_write) begin
      rx_dis_tx  <= wr_rx_dis_tx;
      iface_mode <= wr_iface_mode;
    end
  end

  AST_LOCKED_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked_write |=> ($stable(rx_dis_tx) && $stable(iface_mode))); // R10
  AST_OPEN_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    open_write |=> (rx_dis_tx == $past(wr_rx_dis_tx) && iface_mode == $past(wr_iface_mode))); // R10
  AST_LIMIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (max_len == $past(wr_max_len))); // R10

endmodule

// File: rtl/rxf_len_count.sv
module rxf_len_count #(
  parameter int unsigned LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic             tx_busy,
  input  logic             rx_dis_tx,
  input  logic [LEN_W-1:0] max_len,
  output logic             frame_beat,
  output logic             blocked_now,
  output logic [LEN_W:0]   cur_len,
  output logic             over_limit,
  output logic             babble_evt,
  output logic             end_evt
);

  localparam int unsigned CNT_W = LEN_W + 1;

  // Saturating step: stops one past the limit.
  function automatic logic [CNT_W-1:0] len_step(input logic [CNT_W-1:0] prev,
                                                input logic [LEN_W-1:0] lim);
    logic [CNT_W-1:0] wide_lim;
    wide_lim = {1'b0, lim};
    if (prev > wide_lim) return prev;
    return prev + CNT_W'(1);
  endfunction

  function automatic logic beyond(input logic [CNT_W-1:0] n,
                                  input logic [LEN_W-1:0] lim);
    return n > {1'b0, lim};
  endfunction

  logic             open_q;
  logic             blocked_q;
  logic             fired_q;
  logic [CNT_W-1:0] cnt_q;

  logic [CNT_W-1:0] prev_len;
  logic             fired_prev;

  assign frame_beat  = beat && (sof || open_q);
  assign blocked_now = sof ? (rx_dis_tx && tx_busy) : blocked_q;
  assign prev_len    = sof ? '0 : cnt_q;
  assign fired_prev  = sof ? 1'b0 : fired_q;
  assign cur_len     = len_step(prev_len, max_len);
  assign over_limit  = beyond(cur_len, max_len);
  assign babble_evt  = frame_beat && !blocked_now && over_limit && !fired_prev;
  assign end_evt     = frame_beat && eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      blocked_q <= 1'b0;
      fired_q   <= 1'b0;
      cnt_q     <= '0;
    end else if (frame_beat) begin
      open_q    <= !eof;
      blocked_q <= blocked_now;
      fired_q   <= fired_prev || babble_evt;
      cnt_q     <= cur_len;
    end
  end

  AST_OPEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_beat && !eof) |=> (open_q && cnt_q != '0)); // R2
  AST_CLOSED_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !open_q); // R11
  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && fired_q && !sof) |-> !babble_evt); // R3
  AST_TX_LATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_beat && !sof) |-> (blocked_now == blocked_q)); // R9

endmodule

// File: rtl/rxf_da_class.sv
module rxf_da_class #(
  parameter int unsigned DA_BYTES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_beat,
  input  logic       sof,
  input  logic [7:0] data,
  output logic       bcast_now
);
  import rxf_pkg::*;

  localparam int unsigned POS_W = $clog2(DA_BYTES + 1);
  localparam logic [POS_W-1:0] DA_LAST = POS_W'(DA_BYTES);

  logic [POS_W-1:0] pos_q;
  logic             ones_q;

  logic [POS_W-1:0] pos_prev;
  logic [POS_W-1:0] pos_now;
  logic             ones_prev;
  logic             ones_now;
  logic             in_da;

  assign pos_prev  = sof ? '0 : pos_q;
  assign ones_prev = sof ? 1'b1 : ones_q;
  assign in_da     = pos_prev < DA_LAST;
  assign ones_now  = in_da ? (ones_prev && data == BCAST_BYTE) : ones_prev;
  assign pos_now   = in_da ? pos_prev + POS_W'(1) : pos_prev;
  assign bcast_now = ones_now && (pos_now == DA_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      ones_q <= 1'b0;
    end else if (frame_beat) begin
      pos_q  <= pos_now;
      ones_q <= ones_now;
    end
  end

  AST_NON_FF_BREAKS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_beat && in_da && data != BCAST_BYTE) |-> !bcast_now); // R4
  AST_SHORT_NOT_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_beat && sof) |-> !bcast_now); // R4

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  end_evt,
  input  logic                  blocked,
  input  logic                  is_bcast,
  input  logic                  station_match,
  input  logic                  over_limit,
  input  logic                  bc_reject,
  input  logic                  promisc,
  output logic                  stat_valid,
  output rxf_pkg::rx_status_t   status
);
  import rxf_pkg::*;

  // Returns {accept, miss} for one address class.
  function automatic logic [1:0] verdict(input addr_kind_e kind,
                                         input logic bc_rej,
                                         input logic prom);
    logic [1:0] r;
    case (kind)
      ADDR_BCAST:   r = bc_rej ? (prom ? 2'b11 : 2'b00) : 2'b10;
      ADDR_STATION: r = 2'b10;
      default:      r = prom ? 2'b11 : 2'b00;
    endcase
    return r;
  endfunction

  addr_kind_e kind;
  logic [1:0] am;

  assign kind = is_bcast ? ADDR_BCAST : (station_match ? ADDR_STATION : ADDR_OTHER);
  assign am   = verdict(kind, bc_reject, promisc);

  assign stat_valid    = end_evt;
  assign status.accept = end_evt && !blocked && am[1];
  assign status.miss   = end_evt && !blocked && am[0];
  assign status.long_f = end_evt && !blocked && over_limit;

  AST_MISS_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    status.miss |-> status.accept); // R6
  AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && blocked) |-> (!status.accept && !status.miss && !status.long_f)); // R8
  AST_BCAST_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && is_bcast && bc_reject && !promisc) |-> !status.accept); // R4
  AST_PROMISC_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && promisc && !blocked) |-> status.accept); // R5

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int unsigned LEN_W       = 14,
  parameter int unsigned DEF_MAX_LEN = 1518,
  parameter int unsigned DA_BYTES    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_enable,
  input  logic             cfg_wr,
  input  logic [LEN_W-1:0] wr_max_len,
  input  logic             wr_bc_reject,
  input  logic             wr_promisc,
  input  logic             wr_rx_dis_tx,
  input  logic             wr_iface_mode,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  input  logic             station_match,
  input  logic             tx_busy,
  output logic             iface_mode,
  output logic             stat_valid,
  output logic             stat_accept,
  output logic             stat_miss,
  output logic             stat_long,
  output logic             irq_babble
);
  import rxf_pkg::*;

  logic [LEN_W-1:0] max_len;
  logic             bc_reject;
  logic             promisc;
  logic             rx_dis_tx;

  // Named internal events, visible to the assertions below.
  logic             frame_beat;
  logic             blocked_now;
  logic [LEN_W:0]   cur_len;
  logic             over_limit;
  logic             babble_evt;
  logic             end_evt;
  logic             bcast_now;
  rx_status_t       status;

  rxf_cfg_reg #(.LEN_W(LEN_W), .DEF_MAX_LEN(DEF_MAX_LEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .cfg_wr(cfg_wr),
    .wr_max_len(wr_max_len), .wr_bc_reject(wr_bc_reject), .wr_promisc(wr_promisc),
    .wr_rx_dis_tx(wr_rx_dis_tx), .wr_iface_mode(wr_iface_mode),
    .max_len(max_len), .bc_reject(bc_reject), .promisc(promisc),
    .rx_dis_tx(rx_dis_tx), .iface_mode(iface_mode)
  );

  rxf_len_count #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .beat(rx_valid), .sof(rx_sof), .eof(rx_eof),
    .tx_busy(tx_busy), .rx_dis_tx(rx_dis_tx), .max_len(max_len),
    .frame_beat(frame_beat), .blocked_now(blocked_now), .cur_len(cur_len),
    .over_limit(over_limit), .babble_evt(babble_evt), .end_evt(end_evt)
  );

  rxf_da_class #(.DA_BYTES(DA_BYTES)) u_da (
    .clk(clk), .rst_n(rst_n), .frame_beat(frame_beat), .sof(rx_sof),
    .data(rx_data), .bcast_now(bcast_now)
  );

  rxf_decide u_dec (
    .clk(clk), .rst_n(rst_n), .end_evt(end_evt), .blocked(blocked_now),
    .is_bcast(bcast_now), .station_match(station_match), .over_limit(over_limit),
    .bc_reject(bc_reject), .promisc(promisc),
    .stat_valid(stat_valid), .status(status)
  );

  assign stat_accept = status.accept;
  assign stat_miss   = status.miss;
  assign stat_long   = status.long_f;
  assign irq_babble  = babble_evt;

  AST_STATUS_ON_END_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (rx_valid && rx_eof)); // R11
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_babble |=> !(irq_babble && !rx_sof)); // R3
  AST_IRQ_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_babble |-> (cur_len == {1'b0, max_len} + (LEN_W+1)'(1))); // R3
  AST_LONG_MEANS_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    stat_long |-> (cur_len > {1'b0, max_len})); // R2

endmodule

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;
  localparam int unsigned LEN_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_enable = 1'b0, cfg_wr = 1'b0;
  logic [LEN_W-1:0] wr_max_len = '0;
  logic wr_bc_reject = 1'b0, wr_promisc = 1'b0, wr_rx_dis_tx = 1'b0, wr_iface_mode = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic station_match = 1'b0, tx_busy = 1'b0;
  logic iface_mode, stat_valid, stat_accept, stat_miss, stat_long, irq_babble;

  always #4 clk = ~clk;  // 125 MHz

  rx_frame_filter #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .cfg_wr(cfg_wr),
    .wr_max_len(wr_max_len), .wr_bc_reject(wr_bc_reject), .wr_promisc(wr_promisc),
    .wr_rx_dis_tx(wr_rx_dis_tx), .wr_iface_mode(wr_iface_mode),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .station_match(station_match), .tx_busy(tx_busy), .iface_mode(iface_mode),
    .stat_valid(stat_valid), .stat_accept(stat_accept), .stat_miss(stat_miss),
    .stat_long(stat_long), .irq_babble(irq_babble)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bench-side configuration model.
  int m_max = 1518;
  bit m_bc = 0, m_prom = 0, m_drt = 0, m_mode = 0;

  typedef struct {
    bit acc;
    bit miss;
    bit lng;
    int irqs;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    irq_seen = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every status beat.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (irq_babble) irq_seen++;
      if (stat_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected status", 1, 0);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(stat_accept == e.acc, {t, " accept"}, int'(stat_accept), int'(e.acc));
          check(stat_miss == e.miss, {t, " miss"}, int'(stat_miss), int'(e.miss));
          check(stat_long == e.lng, {t, " long"}, int'(stat_long), int'(e.lng));
          check(irq_seen == e.irqs, {t, " R3 irq count"}, irq_seen, e.irqs);
        end
        irq_seen = 0;
      end
    end
  end

  task automatic write_cfg(input int mx, input bit bc, input bit pr, input bit drt, input bit md);
    @(posedge clk); #1;
    cfg_wr = 1; wr_max_len = LEN_W'(mx); wr_bc_reject = bc; wr_promisc = pr;
    wr_rx_dis_tx = drt; wr_iface_mode = md;
    m_max = mx; m_bc = bc; m_prom = pr;
    if (!ctrl_enable) begin m_drt = drt; m_mode = md; end
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  // Driver: computes the expected verdict, queues it, then sends the beats.
  // kind: 0 = plain address, 1 = broadcast, 2 = near broadcast (sixth byte FE)
  task automatic send_frame(input string tag, input int len, input int kind,
                            input bit match, input bit tx_start, input bit tx_mid);
    exp_t e;
    bit blk, bc_frame;
    blk = m_drt && tx_start;
    bc_frame = (kind == 1) && (len >= 6);
    if (blk) begin
      e.acc = 0; e.miss = 0; e.lng = 0; e.irqs = 0;
    end else begin
      e.lng  = len > m_max;
      e.irqs = (len > m_max) ? 1 : 0;
      if (bc_frame && m_bc && !m_prom)      begin e.acc = 0; e.miss = 0; end
      else if (bc_frame && m_bc && m_prom)  begin e.acc = 1; e.miss = 1; end
      else if (bc_frame || match)           begin e.acc = 1; e.miss = 0; end
      else if (m_prom)                      begin e.acc = 1; e.miss = 1; end
      else                                  begin e.acc = 0; e.miss = 0; end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    tx_busy = tx_start;
    station_match = match;
    for (int k = 0; k < len; k++) begin
      rx_valid = 1;
      rx_sof = (k == 0);
      rx_eof = (k == len - 1);
      if (k < 6) begin
        if (kind == 1)      rx_data = 8'hFF;
        else if (kind == 2) rx_data = (k == 5) ? 8'hFE : 8'hFF;
        else                rx_data = 8'(8'h02 + k);
      end else begin
        rx_data = 8'(k * 7);
      end
      if (tx_mid && k == len / 2) tx_busy = 1;
      @(posedge clk); #1;
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0; tx_busy = 0; station_match = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(stat_valid == 0, "R1 stat_valid at reset", int'(stat_valid), 0);
    check(irq_babble == 0, "R1 irq at reset", int'(irq_babble), 0);
    check(iface_mode == 0, "R1 iface_mode at reset", int'(iface_mode), 0);

    // Default limit 1518: boundary on both sides.
    send_frame("R1 R2 len 1518 default", 1518, 0, 1, 0, 0);
    send_frame("R1 R2 len 1519 default", 1519, 0, 1, 0, 0);

    // Address classes with default config.
    send_frame("R7 station match", 64, 0, 1, 0, 0);
    send_frame("R7 no match dropped", 64, 0, 0, 0, 0);
    send_frame("R7 broadcast accepted", 64, 1, 0, 0, 0);
    send_frame("R11 single beat frame", 1, 0, 1, 0, 0);

    // Broadcast reject.
    write_cfg(1518, 1, 0, 0, 0);
    send_frame("R4 broadcast rejected", 64, 1, 0, 0, 0);
    send_frame("R4 broadcast with match rejected", 64, 1, 1, 0, 0);
    send_frame("R4 near broadcast no match", 64, 2, 0, 0, 0);
    send_frame("R4 near broadcast match", 64, 2, 1, 0, 0);

    // Promiscuous.
    write_cfg(1518, 1, 1, 0, 0);
    send_frame("R5 broadcast promisc miss", 64, 1, 0, 0, 0);
    send_frame("R6 no match promisc miss", 64, 0, 0, 0, 0);
    send_frame("R6 match promisc", 64, 0, 1, 0, 0);

    // Small limit.
    write_cfg(100, 0, 0, 0, 0);
    send_frame("R2 len 100 at limit", 100, 0, 1, 0, 0);
    send_frame("R3 len 101 over", 101, 0, 1, 0, 0);
    send_frame("R3 len 300 saturate", 300, 0, 1, 0, 0);

    // Receive-on-transmit block.
    send_frame("R8 tx busy block off", 64, 0, 1, 1, 0);
    write_cfg(100, 0, 0, 1, 0);
    send_frame("R8 tx busy blocked", 200, 0, 1, 1, 0);
    send_frame("R9 tx rises mid frame", 200, 0, 1, 0, 1);

    // Locked fields while enabled.
    @(posedge clk); #1 ctrl_enable = 1;
    write_cfg(80, 0, 0, 0, 1);
    @(negedge clk);
    check(iface_mode == 0, "R10 iface_mode locked", int'(iface_mode), 0);
    send_frame("R10 block bit kept", 64, 0, 1, 1, 0);
    send_frame("R10 limit updated", 81, 0, 1, 0, 0);
    @(posedge clk); #1 ctrl_enable = 0;
    write_cfg(80, 0, 0, 0, 1);
    @(negedge clk);
    check(iface_mode == 1, "R10 iface_mode written", int'(iface_mode), 1);
    send_frame("R10 block bit cleared", 64, 0, 1, 1, 0);

    // Stray end beat with no open frame: no status expected.
    @(posedge clk); #1;
    rx_valid = 1; rx_eof = 1; rx_data = 8'h55;
    @(posedge clk); #1;
    rx_valid = 0; rx_eof = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule